// File: doc/BRIEF.md
# Field Region Line Sequencer

This block walks through one readout field of an image-sensor timing generator, one pixel per clock. It keeps a pixel position inside the current line and a line position inside the field. It also splits the field's lines into up to nine regions. For the active region it presents a vertical-sequence number and two mode flags, multiplier and sweep. Downstream waveform generators use these to pick the pattern they drive on each line.

A one-cycle field-start pulse begins a field. At that pulse the block copies every configuration input into shadow registers, so the host may rewrite the configuration while a field is running. The new values are used from the next field onward.

The final line of a field has its own pixel length. When the last pixel of the last line has been counted, the block raises a one-cycle field-end pulse. It then waits, idle, for the next field start.

Top module: `field_region_seq`

## Requirements
- R1: A fieldStart pulse sampled on a clock edge makes pixCount, lineCount and regionIdx zero, and lineStart high, in the following cycle. This holds even when a field is already in progress, which is then abandoned.
- R2: On an ordinary line, pixCount runs 0, 1, … up to L-1 and then wraps to 0, where L is the shadowed line length. A length of 0 behaves like a length of 1.
- R3: lineCount increases by one in the cycle after pixCount wraps. lineStart is high exactly in those cycles of a running field where pixCount is 0.
- R4: The last line is the line numbered F-1, where F is the shadowed field line count (a count of 0 is treated as 1). On that line, pixCount wraps at the last-line length minus 1, with 0 treated as 1. fieldEnd is high for that one final pixel. Afterwards the block is idle: pixCount, lineCount and regionIdx stay 0, and lineStart and fieldEnd stay low until the next fieldStart.
- R5: Regions are entered strictly in order. With region k active, region k+1 becomes active on the first pixel of the line whose number equals change position k+1. Change position k sits at bits [13(k-1)+12 : 13(k-1)] of cfgChangePos, for k = 1 to 8. At most one region step happens per line. A change position of 0, one above the last line, or one already passed never triggers.
- R6: seqSel equals bits [5r+4 : 5r] of cfgSeqSel, where r is regionIdx. The region's 2-bit mode is bits [2r+1 : 2r] of cfgModeSel. Mode bit 1 drives multEn and mode bit 0 drives sweepEn, so 0 means both off, 1 means sweep only, 2 means multiplier only and 3 means both on.
- R7: Configuration inputs are sampled only on a fieldStart edge. A change made during a field has no effect on any output until the next fieldStart.
- R8: regionIdx saturates at 8, the last region. It never exceeds NUM_REGIONS-1.
- R9: During and immediately after reset, before any fieldStart, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fieldStart | input | 1 | One-cycle strobe that begins a field and samples the configuration |
| cfgLineLen | input | 13 | Pixels per ordinary line |
| cfgLastLen | input | 13 | Pixels in the last line of the field |
| cfgFieldLines | input | 13 | Lines in the field |
| cfgChangePos | input | 104 | Change positions (line numbers) for regions 1 to 8, 13 bits each |
| cfgSeqSel | input | 45 | Sequence number for regions 0 to 8, 5 bits each |
| cfgModeSel | input | 18 | Mode (multiplier, sweep) for regions 0 to 8, 2 bits each |
| pixCount | output | 13 | Pixel position in the current line |
| lineCount | output | 13 | Line position in the field |
| regionIdx | output | 4 | Active region |
| seqSel | output | 5 | Sequence number of the active region |
| multEn | output | 1 | Multiplier mode of the active region |
| sweepEn | output | 1 | Sweep mode of the active region |
| lineStart | output | 1 | High on the first pixel of every line of a running field |
| fieldEnd | output | 1 | High on the final pixel of the field |

## Verification
The properties assume fieldStart is a clean synchronous strobe and that reset is applied before the first field. They also rely on the idle state after a field being left only through fieldStart.

The bench drives fieldStart for exactly one cycle, shortly after a rising edge. It rewrites the configuration only after the start edge, never in the same cycle. This keeps the "configuration sampled only at start" rule observable.

Restarts during a field arrive only after at least one full cycle of running. The bench therefore never has to resolve a start pulse that coincides with reset release.

// File: rtl/frs_pkg.sv
package frs_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // sample configuration, clear counters
    logic step;       // one pixel time elapses
    logic lineWrap;   // move to the next line of the same field
    logic fieldWrap;  // field finished, return to idle
  } seqCtl_t;

  // Position flags from datapath to control
  typedef struct packed {
    logic pixZero;
    logic pixEnd;
    logic lastLine;
  } seqStat_t;

endpackage

// File: rtl/frs_ctrl.sv
module frs_ctrl
  import frs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     fieldStart,
  input  seqStat_t stat,
  output seqCtl_t  ctl,
  output logic     lineStart,
  output logic     fieldEnd
);

  logic running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (fieldStart) begin
      running <= 1'b1;
    end else if (ctl.fieldWrap) begin
      running <= 1'b0;
    end
  end

  always_comb begin
    ctl.load      = fieldStart;
    ctl.step      = running && !fieldStart;
    ctl.lineWrap  = ctl.step && stat.pixEnd && !stat.lastLine;
    ctl.fieldWrap = ctl.step && stat.pixEnd && stat.lastLine;
  end

  assign lineStart = running && stat.pixZero;
  assign fieldEnd  = running && stat.pixEnd && stat.lastLine;

endmodule

// File: rtl/frs_region.sv
module frs_region #(
  parameter int NUM_REGIONS = 9,
  parameter int LINE_W      = 13,
  localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic [RIDX_W-1:0]                   regionIdx,
  input  logic [LINE_W-1:0]                   nextLine,
  input  logic [(NUM_REGIONS-1)*LINE_W-1:0]   changePos,
  output logic                                advance
);

  logic [NUM_REGIONS-1:1] hit;

  genvar k;
  generate
    for (k = 1; k < NUM_REGIONS; k++) begin : g_cmp
      assign hit[k] = (changePos[(k-1)*LINE_W +: LINE_W] == nextLine);
    end
  endgenerate

  // Only the region directly after the active one may be entered
  always_comb begin
    advance = 1'b0;
    for (int r = 0; r < NUM_REGIONS - 1; r++) begin
      if (regionIdx == RIDX_W'(r)) advance = hit[r+1];
    end
  end

endmodule

// File: rtl/frs_datapath.sv
module frs_datapath
  import frs_pkg::*;
#(
  parameter int NUM_REGIONS = 9,
  parameter int SEQ_W       = 5,
  parameter int LINE_W      = 13,
  parameter int PIX_W       = 13,
  localparam int MODE_W     = 2,
  localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int CP_W       = (NUM_REGIONS - 1) * LINE_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqCtl_t                       ctl,
  input  logic [PIX_W-1:0]              cfgLineLen,
  input  logic [PIX_W-1:0]              cfgLastLen,
  input  logic [LINE_W-1:0]             cfgFieldLines,
  input  logic [CP_W-1:0]               cfgChangePos,
  input  logic [NUM_REGIONS*SEQ_W-1:0]  cfgSeqSel,
  input  logic [NUM_REGIONS*MODE_W-1:0] cfgModeSel,
  output logic [PIX_W-1:0]              pixCount,
  output logic [LINE_W-1:0]             lineCount,
  output logic [RIDX_W-1:0]             regionIdx,
  output logic [SEQ_W-1:0]              seqSel,
  output logic                          multEn,
  output logic                          sweepEn,
  output seqStat_t                      stat
);

  // Shadow copies taken at field start
  logic [PIX_W-1:0]              lineLenR;
  logic [PIX_W-1:0]              lastLenR;
  logic [LINE_W-1:0]             fieldLinesR;
  logic [CP_W-1:0]               changePosR;
  logic [NUM_REGIONS*SEQ_W-1:0]  seqR;
  logic [NUM_REGIONS*MODE_W-1:0] modeR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineLenR    <= '0;
      lastLenR    <= '0;
      fieldLinesR <= '0;
      changePosR  <= '0;
      seqR        <= '0;
      modeR       <= '0;
    end else if (ctl.load) begin
      lineLenR    <= cfgLineLen;
      lastLenR    <= cfgLastLen;
      fieldLinesR <= cfgFieldLines;
      changePosR  <= cfgChangePos;
      seqR        <= cfgSeqSel;
      modeR       <= cfgModeSel;
    end
  end

  // Position flags; zero lengths collapse to one
  logic [LINE_W:0]   lineNext;
  logic [PIX_W:0]    pixNext;
  logic [PIX_W-1:0]  curLen;
  logic [LINE_W-1:0] nextLine;
  logic              advance;

  assign lineNext      = {1'b0, lineCount} + 1'b1;
  assign pixNext       = {1'b0, pixCount} + 1'b1;
  assign stat.lastLine = (lineNext >= {1'b0, fieldLinesR});
  assign curLen        = stat.lastLine ? lastLenR : lineLenR;
  assign stat.pixEnd   = (pixNext >= {1'b0, curLen});
  assign stat.pixZero  = (pixCount == '0);
  assign nextLine      = lineNext[LINE_W-1:0];

  frs_region #(
    .NUM_REGIONS (NUM_REGIONS),
    .LINE_W      (LINE_W)
  ) u_region (
    .regionIdx (regionIdx),
    .nextLine  (nextLine),
    .changePos (changePosR),
    .advance   (advance)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCount  <= '0;
      lineCount <= '0;
      regionIdx <= '0;
    end else if (ctl.load || ctl.fieldWrap) begin
      pixCount  <= '0;
      lineCount <= '0;
      regionIdx <= '0;
    end else if (ctl.lineWrap) begin
      pixCount  <= '0;
      lineCount <= nextLine;
      if (advance) regionIdx <= regionIdx + 1'b1;
    end else if (ctl.step) begin
      pixCount  <= pixNext[PIX_W-1:0];
    end
  end

  // Per-region selection outputs
  logic [MODE_W-1:0] modeCur;

  assign seqSel  = seqR[regionIdx*SEQ_W +: SEQ_W];
  assign modeCur = modeR[regionIdx*MODE_W +: MODE_W];
  assign multEn  = modeCur[1];
  assign sweepEn = modeCur[0];

endmodule

// File: rtl/field_region_seq.sv
module field_region_seq
  import frs_pkg::*;
#(
  parameter int NUM_REGIONS = 9,
  parameter int SEQ_W       = 5,
  parameter int LINE_W      = 13,
  parameter int PIX_W       = 13,
  localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               fieldStart,
  input  logic [PIX_W-1:0]                   cfgLineLen,
  input  logic [PIX_W-1:0]                   cfgLastLen,
  input  logic [LINE_W-1:0]                  cfgFieldLines,
  input  logic [(NUM_REGIONS-1)*LINE_W-1:0]  cfgChangePos,
  input  logic [NUM_REGIONS*SEQ_W-1:0]       cfgSeqSel,
  input  logic [NUM_REGIONS*2-1:0]           cfgModeSel,
  output logic [PIX_W-1:0]                   pixCount,
  output logic [LINE_W-1:0]                  lineCount,
  output logic [RIDX_W-1:0]                  regionIdx,
  output logic [SEQ_W-1:0]                   seqSel,
  output logic                               multEn,
  output logic                               sweepEn,
  output logic                               lineStart,
  output logic                               fieldEnd
);

  seqCtl_t  ctl;
  seqStat_t stat;

  frs_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fieldStart (fieldStart),
    .stat       (stat),
    .ctl        (ctl),
    .lineStart  (lineStart),
    .fieldEnd   (fieldEnd)
  );

  frs_datapath #(
    .NUM_REGIONS (NUM_REGIONS),
    .SEQ_W       (SEQ_W),
    .LINE_W      (LINE_W),
    .PIX_W       (PIX_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .cfgLineLen    (cfgLineLen),
    .cfgLastLen    (cfgLastLen),
    .cfgFieldLines (cfgFieldLines),
    .cfgChangePos  (cfgChangePos),
    .cfgSeqSel     (cfgSeqSel),
    .cfgModeSel    (cfgModeSel),
    .pixCount      (pixCount),
    .lineCount     (lineCount),
    .regionIdx     (regionIdx),
    .seqSel        (seqSel),
    .multEn        (multEn),
    .sweepEn       (sweepEn),
    .stat          (stat)
  );

endmodule

// File: rtl/frs_checker.sv
module frs_checker #(
  parameter int NUM_REGIONS = 9,
  parameter int SEQ_W       = 5,
  parameter int LINE_W      = 13,
  parameter int PIX_W       = 13,
  localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              fieldStart,
  input logic [PIX_W-1:0]  pixCount,
  input logic [LINE_W-1:0] lineCount,
  input logic [RIDX_W-1:0] regionIdx,
  input logic [SEQ_W-1:0]  seqSel,
  input logic              multEn,
  input logic              sweepEn,
  input logic              lineStart,
  input logic              fieldEnd
);

  // R1: start clears the position and opens line 0
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |=> (pixCount == '0 && lineCount == '0 && regionIdx == '0 && lineStart));

  // R3: the line number only moves together with a pixel wrap
  p_line_on_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    !fieldStart |=> ($stable(lineCount) || pixCount == '0));

  // R4: field end lasts one cycle and is followed by idle
  p_end_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fieldEnd && !fieldStart) |=> (!fieldEnd && !lineStart));

  // R5: regions never go back within a field
  p_region_mono_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!fieldStart && !fieldEnd) |=> (regionIdx >= $past(regionIdx)));

  // R5: at most one region step per line
  p_region_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!fieldStart && !fieldEnd) |=>
      (regionIdx == $past(regionIdx) || regionIdx == RIDX_W'($past(regionIdx) + 1'b1)));

  // R6: selection outputs only change on a line boundary
  p_sel_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !fieldStart |=> ($stable({seqSel, multEn, sweepEn}) || pixCount == '0));

  // R8: region index stays within the region count
  p_region_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    regionIdx <= RIDX_W'(NUM_REGIONS - 1));

endmodule

bind field_region_seq frs_checker #(
  .NUM_REGIONS (NUM_REGIONS),
  .SEQ_W       (SEQ_W),
  .LINE_W      (LINE_W),
  .PIX_W       (PIX_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .fieldStart (fieldStart),
  .pixCount   (pixCount),
  .lineCount  (lineCount),
  .regionIdx  (regionIdx),
  .seqSel     (seqSel),
  .multEn     (multEn),
  .sweepEn    (sweepEn),
  .lineStart  (lineStart),
  .fieldEnd   (fieldEnd)
);

// File: tb/field_region_seq_tb.sv
`timescale 1ns/1ps
module field_region_seq_tb;
  localparam int N  = 9;
  localparam int SW = 5;
  localparam int LW = 13;
  localparam int PW = 13;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                rstN = 1'b0;
  logic                fieldStart = 1'b0;
  logic [PW-1:0]       cfgLineLen = '0;
  logic [PW-1:0]       cfgLastLen = '0;
  logic [LW-1:0]       cfgFieldLines = '0;
  logic [(N-1)*LW-1:0] cfgChangePos = '0;
  logic [N*SW-1:0]     cfgSeqSel = '0;
  logic [N*2-1:0]      cfgModeSel = '0;
  logic [PW-1:0]       pixCount;
  logic [LW-1:0]       lineCount;
  logic [3:0]          regionIdx;
  logic [SW-1:0]       seqSel;
  logic                multEn, sweepEn, lineStart, fieldEnd;

  field_region_seq u_dut (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart),
    .cfgLineLen(cfgLineLen), .cfgLastLen(cfgLastLen), .cfgFieldLines(cfgFieldLines),
    .cfgChangePos(cfgChangePos), .cfgSeqSel(cfgSeqSel), .cfgModeSel(cfgModeSel),
    .pixCount(pixCount), .lineCount(lineCount), .regionIdx(regionIdx),
    .seqSel(seqSel), .multEn(multEn), .sweepEn(sweepEn),
    .lineStart(lineStart), .fieldEnd(fieldEnd)
  );

  typedef struct packed {
    logic [PW-1:0] pix;
    logic [LW-1:0] line;
    logic [3:0]    rgn;
    logic [SW-1:0] seq;
    logic          mult;
    logic          sweep;
    logic          ls;
    logic          fe;
  } exp_t;

  exp_t expQ[$];
  exp_t e;
  int   nCmp = 0;
  int   nBad = 0;

  int cpA[N];
  int seqA[N];
  int modeA[N];
  int lenV, lastV, linesV;

  task automatic applyCfg();
    cfgLineLen    = PW'(lenV);
    cfgLastLen    = PW'(lastV);
    cfgFieldLines = LW'(linesV);
    for (int k = 1; k < N; k++) cfgChangePos[(k-1)*LW +: LW] = LW'(cpA[k]);
    for (int k = 0; k < N; k++) begin
      cfgSeqSel[k*SW +: SW] = SW'(seqA[k]);
      cfgModeSel[k*2 +: 2]  = 2'(modeA[k]);
    end
  endtask

  function automatic exp_t mk(int p, int l, int r, bit ls, bit fe);
    exp_t x;
    x.pix = PW'(p); x.line = LW'(l); x.rgn = 4'(r);
    x.seq = SW'(seqA[r]);
    x.mult = modeA[r][1]; x.sweep = modeA[r][0];   // R6 mode bit meaning
    x.ls = ls; x.fe = fe;
    return x;
  endfunction

  // Expected field built from the requirements, pushed to the scoreboard
  task automatic pushField(int maxItems, int idleItems);
    int nl = (linesV == 0) ? 1 : linesV;
    int rg = 0;
    int cnt = 0;
    for (int l = 0; l < nl; l++) begin
      int len;
      if (l > 0 && rg < N-1 && cpA[rg+1] == l) rg++;
      if (l == nl-1) len = (lastV == 0) ? 1 : lastV;
      else           len = (lenV == 0) ? 1 : lenV;
      for (int p = 0; p < len; p++) begin
        if (cnt < maxItems) expQ.push_back(mk(p, l, rg, p == 0, (l == nl-1) && (p == len-1)));
        cnt++;
      end
    end
    if (cnt <= maxItems)
      for (int i = 0; i < idleItems; i++) expQ.push_back(mk(0, 0, 0, 1'b0, 1'b0));
  endtask

  task automatic startField(int maxItems, int idleItems);
    applyCfg();
    @(posedge clk); #1 fieldStart = 1'b1;
    @(posedge clk); #1 fieldStart = 1'b0;
    pushField(maxItems, idleItems);
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(posedge clk);
    #1;
  endtask

  // Monitor: pop and compare on the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      string tag;
      e = expQ.pop_front();
      nCmp++;
      tag = "";
      if (pixCount != e.pix)                                   tag = "R2";
      else if (lineCount != e.line || lineStart != e.ls)       tag = "R3";
      else if (fieldEnd != e.fe)                               tag = "R4";
      else if (regionIdx != e.rgn)                             tag = "R5";
      else if (seqSel != e.seq || multEn != e.mult || sweepEn != e.sweep) tag = "R6";
      if (tag != "") begin
        nBad++;
        $display("FAIL %s at %0t: got pix=%0d line=%0d rgn=%0d seq=%0d m=%0b s=%0b ls=%0b fe=%0b, expected pix=%0d line=%0d rgn=%0d seq=%0d m=%0b s=%0b ls=%0b fe=%0b",
          tag, $time, pixCount, lineCount, regionIdx, seqSel, multEn, sweepEn, lineStart, fieldEnd,
          e.pix, e.line, e.rgn, e.seq, e.mult, e.sweep, e.ls, e.fe);
      end
    end
  end

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish();
  end

  initial begin
    // R9: outputs zero after reset, before any start
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    nCmp++;
    if ({pixCount, lineCount, regionIdx, seqSel, multEn, sweepEn, lineStart, fieldEnd} != '0) begin
      nBad++;
      $display("FAIL R9: got pix=%0d line=%0d rgn=%0d seq=%0d ls=%0b fe=%0b, expected all 0",
        pixCount, lineCount, regionIdx, seqSel, lineStart, fieldEnd);
    end

    // Basic field with every region used and all four modes (R2 R3 R4 R5 R6)
    lenV = 4; lastV = 2; linesV = 12;
    for (int k = 0; k < N; k++) begin seqA[k] = 3*k + 1; modeA[k] = k % 4; end
    cpA[0] = 0; cpA[1] = 2; cpA[2] = 4; cpA[3] = 5; cpA[4] = 7;
    cpA[5] = 8; cpA[6] = 9; cpA[7] = 10; cpA[8] = 11;
    startField(100000, 3);
    drain();

    // Zero and one lengths, zero line count: one-line field (R2 R4)
    lenV = 0; lastV = 0; linesV = 0;
    startField(100000, 2);
    drain();
    lenV = 1; lastV = 3; linesV = 3;
    startField(100000, 2);
    drain();

    // Change position 0, an out-of-order position, and one past the end (R5)
    lenV = 3; lastV = 3; linesV = 8;
    cpA[1] = 0; cpA[2] = 2;
    startField(100000, 2);
    drain();
    cpA[1] = 3; cpA[2] = 2; cpA[3] = 5;
    startField(100000, 2);
    drain();
    cpA[1] = 4; cpA[2] = 9;
    startField(100000, 2);
    drain();

    // Several positions on the same line and saturation at the last region (R5 R8)
    lenV = 2; lastV = 1; linesV = 14;
    for (int k = 1; k < N; k++) cpA[k] = k;
    cpA[3] = 3; cpA[4] = 3;
    startField(100000, 2);
    drain();
    for (int k = 1; k < N; k++) cpA[k] = k;
    startField(100000, 2);
    drain();

    // R7: configuration rewritten during a field has no effect until the next start
    lenV = 3; lastV = 2; linesV = 9;
    for (int k = 1; k < N; k++) cpA[k] = k;
    startField(100000, 2);
    begin
      int sl = lenV, sla = lastV, sn = linesV;
      int scp[N], ss[N], sm[N];
      scp = cpA; ss = seqA; sm = modeA;
      lenV = 5; lastV = 4; linesV = 4;
      for (int k = 0; k < N; k++) begin seqA[k] = 31 - k; modeA[k] = 3 - (k % 4); end
      for (int k = 1; k < N; k++) cpA[k] = 1;
      applyCfg();
      drain();
      lenV = sl; lastV = sla; linesV = sn; cpA = scp; seqA = ss; modeA = sm;
    end
    // New values apply on the next field
    lenV = 5; lastV = 4; linesV = 4;
    for (int k = 0; k < N; k++) begin seqA[k] = 31 - k; modeA[k] = 3 - (k % 4); end
    for (int k = 1; k < N; k++) cpA[k] = 1;
    startField(100000, 2);
    drain();

    // R1: restart partway through a field
    lenV = 4; lastV = 4; linesV = 10;
    for (int k = 1; k < N; k++) cpA[k] = k + 1;
    startField(9, 0);
    drain();
    lenV = 2; lastV = 3; linesV = 5;
    for (int k = 0; k < N; k++) seqA[k] = k + 10;
    startField(100000, 2);
    drain();

    finish();
  end

endmodule